// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Output Pipeline

This block is a synchronous two-port memory. Both ports share one clock and one storage array, and either port can read or write. Each port has its own read latch. On an enabled cycle the latch captures the addressed word. On a write cycle it captures the word being written. Behind the latch, each port can optionally add a register next to the array, a second register at the block's output, or both. The read latency of a port is therefore one, two or three cycles, and it is fixed by parameters at build time.

The output registers of a port load either on a dedicated register clock enable input or on the port enable, as a per-port parameter selects. Each port's synchronous reset clears an output register only in a cycle where that register is enabled. A port with no output register resets its read latch instead. A port with only the first register can be built so that reset also clears the latch. This lets large or fast memories trade read latency for timing margin, port by port, with reset and stall behaviour that can be predicted.

Top module: `dp_ram_pipe`

## Requirements
- R1: When a port's enable and write enable are both high at a clock edge, the write data is stored at that port's address. The port's reset input never changes stored words.
- R2: A port's read data reaches its output one cycle after the edge that loads its read latch. Each output register built into that port (first stage, second stage, or both) adds one more cycle.
- R3: A port's output registers load only at edges where their stage clock enable is high. The stage clock enable is the register clock enable input when that port's register-enable parameter is 1, and the port enable when it is 0. Otherwise the registers hold their value.
- R4: With its enable low, a port's read latch keeps its previous value, even if the address and write inputs change.
- R5: On a write, a port's read latch takes the newly written data (write-first), not the old contents.
- R6: Reset drives an output register to the reset-value parameter only at an edge where that register's stage clock enable is high. Reset takes priority over loading data. With the stage clock enable low, reset has no effect.
- R7: On a port built with no output register, reset together with the port enable drives the read latch, and so the output, to the reset value.
- R8: On a port built with only the first output register and the latch-clear parameter set, reset together with the port enable also drives the read latch to the reset value. A later edge with the stage enabled and the port enable low then loads the reset value again.
- R9: When one port reads an address at the same edge the other port writes it, the reader gets the old word, and a later read returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| addrA | input | ADDR_W | Port A address |
| wdataA | input | DATA_W | Port A write data |
| regceA | input | 1 | Port A output register clock enable |
| rstA | input | 1 | Port A synchronous output reset |
| doutA | output | DATA_W | Port A read data |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| addrB | input | ADDR_W | Port B address |
| wdataB | input | DATA_W | Port B write data |
| regceB | input | 1 | Port B output register clock enable |
| rstB | input | 1 | Port B synchronous output reset |
| doutB | output | DATA_W | Port B read data |

## Verification
A wrong word in the array or in a read latch shows up at the output as a wrong value, one to three cycles after the read, depending on how many stages that port has. A stage that loads on the wrong enable, or that obeys reset while disabled, shows a value on the very next edge that differs from the delayed reference. A latch that misses its clear shows up only on the next enabled stage load in latch-clear mode. Three builds cover all four stage patterns and both enable sources, and every port is compared with a delayed behavioural model on every cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // strobes from a port's control to the array read latch
  typedef struct packed {
    logic load;
    logic clr;
  } latchCtl_t;

  // strobes from a port's control to its output stages
  typedef struct packed {
    logic s1Load;
    logic s1Clr;
    logic s2Load;
    logic s2Clr;
  } stageCtl_t;

endpackage

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl
  import dpr_pkg::*;
#(
  parameter bit OUT1      = 1'b0,
  parameter bit OUT2      = 1'b0,
  parameter bit USE_REGCE = 1'b0,
  parameter bit LATCH_CLR = 1'b0
) (
  input  logic      en,
  input  logic      regce,
  input  logic      rst,
  output latchCtl_t latchCtl,
  output stageCtl_t stageCtl
);

  localparam bit HAS_STAGE    = OUT1 || OUT2;
  localparam bit LATCH_RESETS = !HAS_STAGE || (OUT1 && !OUT2 && LATCH_CLR);

  logic stageCe;

  generate
    if (USE_REGCE) begin : g_regce
      assign stageCe = regce;
    end else begin : g_portce
      logic unusedRegce;
      assign unusedRegce = regce;
      assign stageCe     = en;
    end
  endgenerate

  always_comb begin
    latchCtl.load   = en;
    latchCtl.clr    = LATCH_RESETS && en && rst;
    stageCtl.s1Load = OUT1 && stageCe;
    stageCtl.s1Clr  = OUT1 && stageCe && rst;
    stageCtl.s2Load = OUT2 && stageCe;
    stageCtl.s2Clr  = OUT2 && stageCe && rst;
  end

endmodule

// File: rtl/dpr_array.sv
module dpr_array
  import dpr_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 4,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  latchCtl_t         latchCtlA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] wdataA,
  output logic [DATA_W-1:0] latchA,
  input  latchCtl_t         latchCtlB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] wdataB,
  output logic [DATA_W-1:0] latchB
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NPORTS = 2;

  logic [DATA_W-1:0] mem [DEPTH];

  latchCtl_t         ctl   [NPORTS];
  logic              wr    [NPORTS];
  logic [ADDR_W-1:0] ad    [NPORTS];
  logic [DATA_W-1:0] wd    [NPORTS];
  logic [DATA_W-1:0] rdLat [NPORTS];

  assign ctl[0] = latchCtlA;
  assign ctl[1] = latchCtlB;
  assign wr[0]  = weA;
  assign wr[1]  = weB;
  assign ad[0]  = addrA;
  assign ad[1]  = addrB;
  assign wd[0]  = wdataA;
  assign wd[1]  = wdataB;

  // array update; same-address writes from both ports are undefined
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORTS; p++) begin
      if (ctl[p].load && wr[p]) mem[ad[p]] <= wd[p];
    end
  end

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_latch
      always_ff @(posedge clk) begin
        if (ctl[p].clr)       rdLat[p] <= RST_VAL;
        else if (ctl[p].load) rdLat[p] <= wr[p] ? wd[p] : mem[ad[p]];
      end
    end
  endgenerate

  assign latchA = rdLat[0];
  assign latchB = rdLat[1];

endmodule

// File: rtl/dpr_out_pipe.sv
module dpr_out_pipe
  import dpr_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter bit                OUT1    = 1'b0,
  parameter bit                OUT2    = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  stageCtl_t         stageCtl,
  input  logic [DATA_W-1:0] latchQ,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] s1Q;
  logic [DATA_W-1:0] s2Q;

  generate
    if (OUT1) begin : g_s1
      always_ff @(posedge clk) begin
        if (stageCtl.s1Clr)       s1Q <= RST_VAL;
        else if (stageCtl.s1Load) s1Q <= latchQ;
      end
    end else begin : g_no_s1
      logic [1:0] unusedS1;
      assign unusedS1 = {stageCtl.s1Load, stageCtl.s1Clr};
      assign s1Q      = latchQ;
    end

    if (OUT2) begin : g_s2
      always_ff @(posedge clk) begin
        if (stageCtl.s2Clr)       s2Q <= RST_VAL;
        else if (stageCtl.s2Load) s2Q <= s1Q;
      end
    end else begin : g_no_s2
      logic [1:0] unusedS2;
      assign unusedS2 = {stageCtl.s2Load, stageCtl.s2Clr};
      assign s2Q      = s1Q;
    end
  endgenerate

  assign dout = s2Q;

endmodule

// File: rtl/dp_ram_pipe.sv
module dp_ram_pipe
  import dpr_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 4,
  parameter logic [DATA_W-1:0] RST_VAL     = '0,
  parameter bit                A_OUT1      = 1'b1,
  parameter bit                A_OUT2      = 1'b0,
  parameter bit                A_USE_REGCE = 1'b0,
  parameter bit                A_LATCH_CLR = 1'b0,
  parameter bit                B_OUT1      = 1'b1,
  parameter bit                B_OUT2      = 1'b1,
  parameter bit                B_USE_REGCE = 1'b1,
  parameter bit                B_LATCH_CLR = 1'b0
) (
  input  logic              clk,
  input  logic              enA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] wdataA,
  input  logic              regceA,
  input  logic              rstA,
  output logic [DATA_W-1:0] doutA,
  input  logic              enB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] wdataB,
  input  logic              regceB,
  input  logic              rstB,
  output logic [DATA_W-1:0] doutB
);

  latchCtl_t         latchCtlA, latchCtlB;
  stageCtl_t         stageCtlA, stageCtlB;
  logic [DATA_W-1:0] latchA, latchB;

  dpr_port_ctl #(
    .OUT1(A_OUT1), .OUT2(A_OUT2), .USE_REGCE(A_USE_REGCE), .LATCH_CLR(A_LATCH_CLR)
  ) i_ctlA (
    .en(enA), .regce(regceA), .rst(rstA), .latchCtl(latchCtlA), .stageCtl(stageCtlA)
  );

  dpr_port_ctl #(
    .OUT1(B_OUT1), .OUT2(B_OUT2), .USE_REGCE(B_USE_REGCE), .LATCH_CLR(B_LATCH_CLR)
  ) i_ctlB (
    .en(enB), .regce(regceB), .rst(rstB), .latchCtl(latchCtlB), .stageCtl(stageCtlB)
  );

  dpr_array #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_VAL(RST_VAL)
  ) i_array (
    .clk(clk),
    .latchCtlA(latchCtlA), .weA(weA), .addrA(addrA), .wdataA(wdataA), .latchA(latchA),
    .latchCtlB(latchCtlB), .weB(weB), .addrB(addrB), .wdataB(wdataB), .latchB(latchB)
  );

  dpr_out_pipe #(
    .DATA_W(DATA_W), .OUT1(A_OUT1), .OUT2(A_OUT2), .RST_VAL(RST_VAL)
  ) i_pipeA (
    .clk(clk), .stageCtl(stageCtlA), .latchQ(latchA), .dout(doutA)
  );

  dpr_out_pipe #(
    .DATA_W(DATA_W), .OUT1(B_OUT1), .OUT2(B_OUT2), .RST_VAL(RST_VAL)
  ) i_pipeB (
    .clk(clk), .stageCtl(stageCtlB), .latchQ(latchB), .dout(doutB)
  );

endmodule

// File: rtl/dpr_port_checker.sv
module dpr_port_checker #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] RST_VAL   = '0,
  parameter bit                OUT1      = 1'b0,
  parameter bit                OUT2      = 1'b0,
  parameter bit                USE_REGCE = 1'b0,
  parameter bit                LATCH_CLR = 1'b0
) (
  input logic              clk,
  input logic              en,
  input logic              we,
  input logic              regce,
  input logic              rst,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] dout
);

  localparam bit HAS_STAGE = OUT1 || OUT2;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic ce;
  assign ce = (HAS_STAGE && USE_REGCE) ? regce : en;

  AST_RESET_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!armed)
    (rst && ce) |=> (dout == RST_VAL)); // R6

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!armed)
    !ce |=> $stable(dout)); // R3

  generate
    if (!HAS_STAGE) begin : g_flat
      AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!armed)
        (en && we && !rst) |=> (dout == $past(wdata))); // R5
    end
    if (OUT1 && !OUT2 && LATCH_CLR) begin : g_lclr
      AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!armed)
        (rst && en && ce) ##1 (ce && !en && !rst) |=> (dout == RST_VAL)); // R8
    end
  endgenerate

endmodule

bind dp_ram_pipe dpr_port_checker #(
  .DATA_W(DATA_W), .RST_VAL(RST_VAL), .OUT1(A_OUT1), .OUT2(A_OUT2),
  .USE_REGCE(A_USE_REGCE), .LATCH_CLR(A_LATCH_CLR)
) i_chkA (
  .clk(clk), .en(enA), .we(weA), .regce(regceA), .rst(rstA), .wdata(wdataA), .dout(doutA)
);

bind dp_ram_pipe dpr_port_checker #(
  .DATA_W(DATA_W), .RST_VAL(RST_VAL), .OUT1(B_OUT1), .OUT2(B_OUT2),
  .USE_REGCE(B_USE_REGCE), .LATCH_CLR(B_LATCH_CLR)
) i_chkB (
  .clk(clk), .en(enB), .we(weB), .regce(regceB), .rst(rstB), .wdata(wdataB), .dout(doutB)
);

// File: tb/test_dp_ram_pipe.sv
module test_dp_ram_pipe;

  localparam int         CLK_PERIOD = 10;
  localparam int         DW    = 8;
  localparam int         AW    = 4;
  localparam int         NCFG  = 3;
  localparam logic [7:0] RV    = 8'hA5;
  // per build k: bit k of each mask (k = 0..2)
  localparam bit [0:2] A_S1 = 3'b011, A_S2 = 3'b010, A_UR = 3'b010, A_LC = 3'b000;
  localparam bit [0:2] B_S1 = 3'b101, B_S2 = 3'b011, B_UR = 3'b100, B_LC = 3'b100;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          en[2], we[2], rc[2], rs[2];
  logic [AW-1:0] ad[2];
  logic [DW-1:0] wd[2];
  logic [DW-1:0] dA[NCFG], dB[NCFG];

  generate
    for (genvar g = 0; g < NCFG; g++) begin : g_dut
      dp_ram_pipe #(
        .DATA_W(DW), .ADDR_W(AW), .RST_VAL(RV),
        .A_OUT1(A_S1[g]), .A_OUT2(A_S2[g]), .A_USE_REGCE(A_UR[g]), .A_LATCH_CLR(A_LC[g]),
        .B_OUT1(B_S1[g]), .B_OUT2(B_S2[g]), .B_USE_REGCE(B_UR[g]), .B_LATCH_CLR(B_LC[g])
      ) i_dp_ram_pipe (
        .clk(clk),
        .enA(en[0]), .weA(we[0]), .addrA(ad[0]), .wdataA(wd[0]),
        .regceA(rc[0]), .rstA(rs[0]), .doutA(dA[g]),
        .enB(en[1]), .weB(we[1]), .addrB(ad[1]), .wdataB(wd[1]),
        .regceB(rc[1]), .rstB(rs[1]), .doutB(dB[g])
      );
    end
  endgenerate

  // behavioural reference
  logic [DW-1:0] mem [16];
  logic [DW-1:0] mLat[NCFG][2], mS1[NCFG][2], mS2[NCFG][2];
  int checks = 0;
  int errors = 0;

  function automatic bit cfgBit(input bit [0:2] a, input bit [0:2] b, input int k, input int p);
    return p == 0 ? a[k] : b[k];
  endfunction

  task automatic modelStep();
    logic [DW-1:0] nLat, nS1, nS2;
    bit s1, s2, ur, lc, ce, latchRst;
    for (int k = 0; k < NCFG; k++) begin
      for (int p = 0; p < 2; p++) begin
        s1 = cfgBit(A_S1, B_S1, k, p);
        s2 = cfgBit(A_S2, B_S2, k, p);
        ur = cfgBit(A_UR, B_UR, k, p);
        lc = cfgBit(A_LC, B_LC, k, p);
        ce = ur ? rc[p] : en[p];
        latchRst = (!s1 && !s2) || (s1 && !s2 && lc);
        nLat = mLat[k][p];
        if (en[p]) nLat = (rs[p] && latchRst) ? RV : (we[p] ? wd[p] : mem[ad[p]]);
        nS1 = mS1[k][p];
        if (s1 && ce) nS1 = rs[p] ? RV : mLat[k][p];
        nS2 = mS2[k][p];
        if (s2 && ce) nS2 = rs[p] ? RV : (s1 ? mS1[k][p] : mLat[k][p]);
        mLat[k][p] = nLat;
        mS1[k][p]  = nS1;
        mS2[k][p]  = nS2;
      end
    end
    for (int p = 0; p < 2; p++) if (en[p] && we[p]) mem[ad[p]] = wd[p];
  endtask

  task automatic compareAll(input string tag);
    logic [DW-1:0] expV, got;
    bit s1, s2;
    for (int k = 0; k < NCFG; k++) begin
      for (int p = 0; p < 2; p++) begin
        s1   = cfgBit(A_S1, B_S1, k, p);
        s2   = cfgBit(A_S2, B_S2, k, p);
        expV = s2 ? mS2[k][p] : (s1 ? mS1[k][p] : mLat[k][p]);
        got  = p == 0 ? dA[k] : dB[k];
        if (!$isunknown(expV)) begin
          checks++;
          if (got !== expV) begin
            errors++;
            $display("FAIL %s build%0d port%0d got %h expected %h", tag, k, p, got, expV);
          end
        end
      end
    end
  endtask

  task automatic run(input string tag);
    modelStep();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic setPort(input int p, input bit e, input bit w, input logic [AW-1:0] a,
                         input bit r, input bit c);
    en[p] = e; we[p] = w; ad[p] = a; wd[p] = DW'($urandom); rs[p] = r; rc[p] = c;
  endtask

  initial begin
    for (int p = 0; p < 2; p++) setPort(p, 0, 0, '0, 0, 0);
    @(negedge clk);
    // R6: reset with stages enabled gives RST value on every staged port
    for (int i = 0; i < 3; i++) begin
      for (int p = 0; p < 2; p++) setPort(p, 1, 0, AW'(i), 1, 1);
      run("R6 R7 reset");
    end
    // R1: fill both halves of the array
    for (int i = 0; i < 8; i++) begin
      setPort(0, 1, 1, AW'(i), 0, 1);
      setPort(1, 1, 1, AW'(i + 8), 0, 1);
      run("R1 fill");
    end
    // R2: streaming reads
    for (int i = 0; i < 40; i++) begin
      for (int p = 0; p < 2; p++) setPort(p, 1, 0, AW'($urandom), 0, 1);
      run("R2 latency");
    end
    // R3 R4: stalls on enable and on register clock enable
    for (int i = 0; i < 60; i++) begin
      for (int p = 0; p < 2; p++)
        setPort(p, 1'($urandom), 1'($urandom_range(0, 3) == 0), AW'($urandom % 8 + p * 8), 0,
                1'($urandom));
      run("R3 R4 stall");
    end
    // R5: mixed reads and writes, write-first
    for (int i = 0; i < 60; i++) begin
      for (int p = 0; p < 2; p++)
        setPort(p, 1, 1'($urandom), AW'($urandom % 8 + p * 8), 0, 1);
      run("R5 write-first");
    end
    // R6: reset under random enables; memory must survive it
    for (int i = 0; i < 80; i++) begin
      for (int p = 0; p < 2; p++)
        setPort(p, 1'($urandom), 1'($urandom), AW'($urandom % 8 + p * 8),
                1'($urandom_range(0, 2) == 0), 1'($urandom));
      run("R6 gated reset");
    end
    // R7 R8: reset with enable then stage load with port idle
    for (int i = 0; i < 20; i++) begin
      for (int p = 0; p < 2; p++) setPort(p, 1, 0, AW'($urandom), 1, 1);
      run("R7 R8 latch clear");
      for (int p = 0; p < 2; p++) setPort(p, 0, 0, AW'($urandom), 0, 1);
      run("R7 R8 latch clear");
      for (int p = 0; p < 2; p++) setPort(p, 1, 0, AW'($urandom), 0, 1);
      run("R7 R8 latch clear");
    end
    // R9: A writes what B reads in the same cycle, then B reads again
    for (int i = 0; i < 20; i++) begin
      setPort(0, 1, 1, AW'(i % 16), 0, 1);
      setPort(1, 1, 0, AW'(i % 16), 0, 1);
      run("R9 cross port");
      setPort(0, 1, 0, AW'($urandom), 0, 1);
      setPort(1, 1, 0, AW'(i % 16), 0, 1);
      run("R9 cross port");
    end
    for (int i = 0; i < 4; i++) run("R2 drain");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule